// File: doc/BRIEF.md
# Precise Pipeline Exception Tracker

This block is the control side of precise exception handling for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It keeps a shadow record per pipeline slot: a valid bit, the instruction address, a pending-exception flag and a cause code. Each stage may report a fault for the instruction it currently holds. The fault is not acted on at once. It is folded into that instruction's record and travels with it. The exception is only taken when the faulting instruction finishes the memory stage.

When the memory-stage instruction carries a fault, the tracker does five things in that cycle. It raises a take strobe, which is also the write enable of the exception address and cause registers. It presents the instruction's address as the exception address and presents the recorded cause. It redirects fetch to a fixed handler vector. It kills the memory-stage side effects of that instruction. It squashes every younger instruction in fetch, decode and execute. The faulting instruction never reaches writeback, and the next fetch starts at the vector. An external interrupt request is converted into a faulting no-op in the fetch slot. That no-op carries the fetch address, so the handler later resumes at the instruction it displaced. The pipeline advances one stage per cycle; the datapath itself lies outside the block.

Top module: `precise_exc_tracker`

## Requirements
- R1: After reset, the decode, execute, memory and writeback slots are all empty and no exception is taken.
- R2: A valid instruction without faults advances one stage per clock. It is reported in writeback with its own address exactly four cycles after it was presented at fetch.
- R3: The take strobe rises only while the memory slot holds a valid instruction whose record carries a fault, or which reports a memory-stage fault in that cycle. It never rises at detection in an earlier stage.
- R4: In the take cycle, the exception address output equals the address of the memory-slot instruction. Redirect is asserted, and its target is the VECTOR parameter.
- R5: Cause codes are 5 bits: external interrupt 0, decode (undefined opcode) 10, execute (arithmetic overflow) 12. Fetch and memory faults supply their own code on an input (for example 4 for address error, 6 or 7 for bus error). If one instruction faults in several stages, the cause from the earliest stage is kept.
- R6: In the cycle after a take, the decode, execute and memory slots are empty, and the faulting instruction does not appear in writeback.
- R7: The memory-kill output, which suppresses the store and register write of the faulting instruction, is asserted exactly in take cycles. The flush output squashes fetch, decode and execute, and it is also asserted exactly in take cycles.
- R8: When an older and a younger instruction both fault, only the older one is taken. The younger one is squashed and never causes a take.
- R9: An interrupt request replaces the fetch slot with a faulting no-op that has cause 0 and the fetch address. That no-op is taken three cycles later.
- R10: While an interrupt no-op is in decode, execute or memory, a held request injects no second no-op. Injection may resume in the cycle after the take.
- R11: Fault inputs reported for an empty slot are ignored and cause no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid_i | input | 1 | Fetch slot holds an instruction |
| if_pc_i | input | PC_W | Fetch slot address |
| if_fault_i | input | 1 | Fetch-stage fault |
| if_code_i | input | 5 | Cause code of the fetch fault |
| id_fault_i | input | 1 | Undefined opcode in decode |
| ex_fault_i | input | 1 | Arithmetic overflow in execute |
| mem_fault_i | input | 1 | Memory-stage fault |
| mem_code_i | input | 5 | Cause code of the memory fault |
| irq_i | input | 1 | External interrupt request |
| id_valid_o | output | 1 | Decode slot occupied |
| ex_valid_o | output | 1 | Execute slot occupied |
| mem_valid_o | output | 1 | Memory slot occupied |
| mem_pc_o | output | PC_W | Memory slot address |
| wb_valid_o | output | 1 | Writeback commits an instruction |
| wb_pc_o | output | PC_W | Writeback address |
| exc_take_o | output | 1 | Exception taken; write enable of the exception address and cause registers |
| flush_o | output | 1 | Squash fetch, decode and execute |
| mem_kill_o | output | 1 | Suppress memory-stage store and result |
| epc_o | output | PC_W | Exception address value |
| cause_o | output | 5 | Cause value |
| redirect_valid_o | output | 1 | Redirect fetch |
| redirect_pc_o | output | PC_W | Redirect target |

## Verification
The bench builds the tracker with a 32-bit address width and the vector at 0x80000180. These values make address comparisons exact and make a redirect easy to tell apart from sequential fetch addresses. Random fault injection at every stage, mixed with held interrupt requests, creates frequent overlaps: one instruction faulting twice, an older and a younger fault in flight together, and an interrupt no-op competing with instruction faults. Directed sequences aim at each priority and squash rule separately.

// File: rtl/pexc_pkg.sv
package pexc_pkg;
    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_INT = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_RI  = 5'd10;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF = 5'd12;
    localparam int N_TRACK = 3;   // decode, execute, memory slots
endpackage

// File: rtl/pexc_merge.sv
// Folds a stage-local fault into a slot record; an earlier fault wins.
module pexc_merge #(
    parameter int PC_W = 32,
    parameter int CW   = 5
) (
    input  logic            in_v,
    input  logic [PC_W-1:0] in_pc,
    input  logic            in_x,
    input  logic [CW-1:0]   in_code,
    input  logic            flt,
    input  logic [CW-1:0]   flt_code,
    output logic            out_v,
    output logic [PC_W-1:0] out_pc,
    output logic            out_x,
    output logic [CW-1:0]   out_code
);
    always_comb begin
        out_v    = in_v;
        out_pc   = in_pc;
        out_x    = in_v & (in_x | flt);
        out_code = in_x ? in_code : flt_code;
    end
endmodule

// File: rtl/pexc_fetch_slot.sv
// Builds the fetch-slot record, turning an interrupt into a faulting no-op.
module pexc_fetch_slot #(
    parameter int PC_W = 32,
    parameter int CW   = 5
) (
    input  logic            if_valid,
    input  logic [PC_W-1:0] if_pc,
    input  logic            if_fault,
    input  logic [CW-1:0]   if_code,
    input  logic            irq,
    input  logic            irq_busy,
    input  logic            take,
    output logic            f_v,
    output logic [PC_W-1:0] f_pc,
    output logic            f_x,
    output logic [CW-1:0]   f_code
);
    logic inject;
    always_comb begin
        inject = irq & ~irq_busy & ~take;
        f_pc   = if_pc;
        if (inject) begin
            f_v    = 1'b1;
            f_x    = 1'b1;
            f_code = pexc_pkg::CAUSE_INT;
        end else begin
            f_v    = if_valid;
            f_x    = if_valid & if_fault;
            f_code = if_code;
        end
    end
endmodule

// File: rtl/precise_exc_tracker.sv
module precise_exc_tracker #(
    parameter int              PC_W   = 32,
    parameter logic [PC_W-1:0] VECTOR = 32'h8000_0180
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         if_valid_i,
    input  logic [PC_W-1:0]              if_pc_i,
    input  logic                         if_fault_i,
    input  logic [pexc_pkg::CAUSE_W-1:0] if_code_i,
    input  logic                         id_fault_i,
    input  logic                         ex_fault_i,
    input  logic                         mem_fault_i,
    input  logic [pexc_pkg::CAUSE_W-1:0] mem_code_i,
    input  logic                         irq_i,
    output logic                         id_valid_o,
    output logic                         ex_valid_o,
    output logic                         mem_valid_o,
    output logic [PC_W-1:0]              mem_pc_o,
    output logic                         wb_valid_o,
    output logic [PC_W-1:0]              wb_pc_o,
    output logic                         exc_take_o,
    output logic                         flush_o,
    output logic                         mem_kill_o,
    output logic [PC_W-1:0]              epc_o,
    output logic [pexc_pkg::CAUSE_W-1:0] cause_o,
    output logic                         redirect_valid_o,
    output logic [PC_W-1:0]              redirect_pc_o
);
    import pexc_pkg::*;
    localparam int CW = CAUSE_W;

    typedef struct packed {
        logic            v;
        logic [PC_W-1:0] pc;
        logic            x;
        logic [CW-1:0]   code;
    } slot_t;

    typedef struct packed {
        slot_t [N_TRACK-1:0] st;   // 0 decode, 1 execute, 2 memory
        slot_t               wb;
    } state_t;

    state_t state_q, state_d;

    // merged records per tracked slot
    logic            m_v    [N_TRACK];
    logic [PC_W-1:0] m_pc   [N_TRACK];
    logic            m_x    [N_TRACK];
    logic [CW-1:0]   m_code [N_TRACK];
    logic            s_flt  [N_TRACK];
    logic [CW-1:0]   s_code [N_TRACK];

    assign s_flt[0]  = id_fault_i;
    assign s_flt[1]  = ex_fault_i;
    assign s_flt[2]  = mem_fault_i;
    assign s_code[0] = CAUSE_RI;
    assign s_code[1] = CAUSE_OVF;
    assign s_code[2] = mem_code_i;

    for (genvar g = 0; g < N_TRACK; g++) begin : g_merge
        pexc_merge #(.PC_W(PC_W), .CW(CW)) u_merge (
            .in_v    (state_q.st[g].v),
            .in_pc   (state_q.st[g].pc),
            .in_x    (state_q.st[g].x),
            .in_code (state_q.st[g].code),
            .flt     (s_flt[g]),
            .flt_code(s_code[g]),
            .out_v   (m_v[g]),
            .out_pc  (m_pc[g]),
            .out_x   (m_x[g]),
            .out_code(m_code[g])
        );
    end

    logic take;
    assign take = m_x[N_TRACK-1];

    // an interrupt no-op is in flight when a slot holds a pending cause 0
    logic irq_busy;
    always_comb begin
        irq_busy = 1'b0;
        for (int i = 0; i < N_TRACK; i++) begin
            if (state_q.st[i].v && state_q.st[i].x && state_q.st[i].code == CAUSE_INT)
                irq_busy = 1'b1;
        end
    end

    logic            f_v, f_x;
    logic [PC_W-1:0] f_pc;
    logic [CW-1:0]   f_code;

    pexc_fetch_slot #(.PC_W(PC_W), .CW(CW)) u_fetch (
        .if_valid(if_valid_i),
        .if_pc   (if_pc_i),
        .if_fault(if_fault_i),
        .if_code (if_code_i),
        .irq     (irq_i),
        .irq_busy(irq_busy),
        .take    (take),
        .f_v     (f_v),
        .f_pc    (f_pc),
        .f_x     (f_x),
        .f_code  (f_code)
    );

    always_comb begin
        state_d = state_q;
        state_d.st[0] = '{v: f_v, pc: f_pc, x: f_x, code: f_code};
        for (int i = 1; i < N_TRACK; i++) begin
            state_d.st[i] = '{v: m_v[i-1], pc: m_pc[i-1], x: m_x[i-1], code: m_code[i-1]};
        end
        state_d.wb = '{v: m_v[N_TRACK-1] & ~take, pc: m_pc[N_TRACK-1], x: 1'b0, code: '0};
        if (take) begin
            for (int i = 0; i < N_TRACK; i++) state_d.st[i].v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign id_valid_o       = state_q.st[0].v;
    assign ex_valid_o       = state_q.st[1].v;
    assign mem_valid_o      = state_q.st[2].v;
    assign mem_pc_o         = state_q.st[2].pc;
    assign wb_valid_o       = state_q.wb.v;
    assign wb_pc_o          = state_q.wb.pc;
    assign exc_take_o       = take;
    assign flush_o          = take;
    assign mem_kill_o       = take;
    assign epc_o            = m_pc[N_TRACK-1];
    assign cause_o          = m_code[N_TRACK-1];
    assign redirect_valid_o = take;
    assign redirect_pc_o    = VECTOR;
endmodule

// File: rtl/precise_exc_tracker_chk.sv
module precise_exc_tracker_chk #(
    parameter int              PC_W   = 32,
    parameter logic [PC_W-1:0] VECTOR = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid_o,
    input logic            ex_valid_o,
    input logic            mem_valid_o,
    input logic [PC_W-1:0] mem_pc_o,
    input logic            wb_valid_o,
    input logic [PC_W-1:0] wb_pc_o,
    input logic            exc_take_o,
    input logic            mem_kill_o,
    input logic            flush_o,
    input logic [PC_W-1:0] epc_o,
    input logic            redirect_valid_o,
    input logic [PC_W-1:0] redirect_pc_o
);
    p_take_in_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_o |-> mem_valid_o);

    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_o |-> (redirect_valid_o && redirect_pc_o == VECTOR && epc_o == mem_pc_o));

    p_squash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_o |=> (!id_valid_o && !ex_valid_o && !mem_valid_o && !wb_valid_o));

    p_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_o |-> (mem_kill_o && flush_o));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !exc_take_o) |=> (wb_valid_o && wb_pc_o == $past(mem_pc_o)));

    p_single_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_o |=> !exc_take_o);
endmodule

bind precise_exc_tracker precise_exc_tracker_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
    .clk(clk), .rst_n(rst_n), .id_valid_o(id_valid_o), .ex_valid_o(ex_valid_o),
    .mem_valid_o(mem_valid_o), .mem_pc_o(mem_pc_o), .wb_valid_o(wb_valid_o),
    .wb_pc_o(wb_pc_o), .exc_take_o(exc_take_o), .mem_kill_o(mem_kill_o),
    .flush_o(flush_o), .epc_o(epc_o), .redirect_valid_o(redirect_valid_o),
    .redirect_pc_o(redirect_pc_o)
);

// File: tb/sim_precise_exc_tracker.sv
module sim_precise_exc_tracker;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        if_valid_i = 0, if_fault_i = 0, id_fault_i = 0, ex_fault_i = 0;
    logic        mem_fault_i = 0, irq_i = 0;
    logic [31:0] if_pc_i = 0;
    logic [4:0]  if_code_i = 0, mem_code_i = 0;
    logic        id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o, exc_take_o;
    logic        flush_o, mem_kill_o, redirect_valid_o;
    logic [31:0] mem_pc_o, wb_pc_o, epc_o, redirect_pc_o;
    logic [4:0]  cause_o;

    precise_exc_tracker #(.PC_W(32), .VECTOR(VEC)) u0 (.*);

    typedef struct {
        bit          v;
        logic [31:0] pc;
        bit          x;
        logic [4:0]  c;
    } ment_t;

    ment_t m_id, m_ex, m_mem, m_wb;
    int unsigned n_vec = 0, n_bad = 0, n_take = 0, n_commit = 0;
    logic [31:0] nxt_pc = 32'h0000_1000;
    logic [31:0] last_epc;
    logic [4:0]  last_cause;
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic ment_t mrg(input ment_t e, input bit f, input logic [4:0] fc);
        ment_t r = e;
        r.x = e.v && (e.x || f);
        r.c = e.x ? e.c : fc;
        return r;
    endfunction

    function automatic bit is_int(input ment_t e);
        return e.v && e.x && e.c == 5'd0;
    endfunction

    task automatic step(input bit fv, input bit ff, input logic [4:0] fc, input bit idf,
                        input bit exf, input bit mf, input logic [4:0] mc, input bit irq);
        ment_t id_m, ex_m, mem_m, fe;
        bit take, inj;
        @(negedge clk);
        if_valid_i = fv; if_pc_i = nxt_pc; if_fault_i = ff; if_code_i = fc;
        id_fault_i = idf; ex_fault_i = exf; mem_fault_i = mf; mem_code_i = mc; irq_i = irq;
        #1;
        id_m  = mrg(m_id, idf, 5'd10);
        ex_m  = mrg(m_ex, exf, 5'd12);
        mem_m = mrg(m_mem, mf, mc);
        take  = mem_m.x;
        inj   = irq && !take && !is_int(m_id) && !is_int(m_ex) && !is_int(m_mem);
        if (inj) fe = '{v: 1, pc: nxt_pc, x: 1, c: 5'd0};
        else     fe = '{v: fv, pc: nxt_pc, x: fv && ff, c: fc};
        // R2 / R6: slot occupancy and writeback address
        chk(id_valid_o == m_id.v && ex_valid_o == m_ex.v && mem_valid_o == m_mem.v,
            "R6 slot valids", {id_valid_o, ex_valid_o, mem_valid_o}, {m_id.v, m_ex.v, m_mem.v});
        chk(wb_valid_o == m_wb.v && (!m_wb.v || wb_pc_o == m_wb.pc), "R2 writeback",
            wb_pc_o, m_wb.pc);
        // R3 / R9 / R11: take only at end of memory stage
        chk(exc_take_o == take, "R3 take", exc_take_o, take);
        chk(mem_kill_o == take && flush_o == take, "R7 kill/flush", {mem_kill_o, flush_o}, {take, take});
        if (take) begin
            chk(epc_o == m_mem.pc && redirect_valid_o && redirect_pc_o == VEC, "R4 epc/redirect",
                epc_o, m_mem.pc);
            chk(cause_o == mem_m.c, "R5 cause", cause_o, mem_m.c);
        end else begin
            chk(!redirect_valid_o, "R4 no redirect", redirect_valid_o, 0);
        end
        if (exc_take_o) begin n_take++; last_epc = epc_o; last_cause = cause_o; end
        if (wb_valid_o) n_commit++;
        @(posedge clk);
        m_wb = mem_m; m_wb.v = mem_m.v && !take; m_wb.x = 0;
        m_mem = ex_m; m_ex = id_m; m_id = fe;
        if (take) begin m_id.v = 0; m_ex.v = 0; m_mem.v = 0; nxt_pc = VEC; end
        else if (fv) nxt_pc = nxt_pc + 4;
    endtask

    task automatic bubbles(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        int unsigned t0;
        logic [31:0] pa, pb;
        m_id = '{default: 0}; m_ex = '{default: 0}; m_mem = '{default: 0}; m_wb = '{default: 0};
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!id_valid_o && !ex_valid_o && !mem_valid_o && !wb_valid_o && !exc_take_o,
            "R1 reset", {id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o, exc_take_o}, 0);

        // R2 clean flow
        t0 = n_commit;
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
        bubbles(5);
        chk(n_commit - t0 == 6, "R2 six commits", n_commit - t0, 6);

        // R5 decode fault
        t0 = n_take; pa = nxt_pc;
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0, 0);
        bubbles(5);
        chk(n_take - t0 == 1 && last_cause == 5'd10, "R5 decode cause", last_cause, 10);
        chk(last_epc == pa, "R4 decode epc", last_epc, pa);

        // R5 earliest stage wins: fetch fault 6 then overflow on the same instruction
        step(1, 1, 5'd6, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        bubbles(4);
        chk(last_cause == 5'd6, "R5 earliest stage", last_cause, 6);

        // R8 older execute fault vs younger decode fault
        t0 = n_take; pa = nxt_pc; pb = pa + 4;
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0, 0, 0);
        bubbles(6);
        chk(n_take - t0 == 1, "R8 one take", n_take - t0, 1);
        chk(last_epc == pa && last_cause == 5'd12, "R8 older wins", last_epc, pa);

        // R9 / R10 interrupt held for 8 cycles: injections at cycles 0 and 4
        t0 = n_take; pa = nxt_pc;
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, 0, 1);
        bubbles(5);
        chk(n_take - t0 == 2, "R10 held request takes", n_take - t0, 2);
        chk(last_cause == 5'd0 && last_epc == VEC, "R9 interrupt noop", last_epc, VEC);

        // R11 faults on empty slots
        t0 = n_take;
        for (int i = 0; i < 6; i++) step(0, 1, 5'd4, 1, 1, 1, 5'd7, 0);
        chk(n_take == t0, "R11 ignored faults", n_take - t0, 0);

        // random mix
        void'($urandom(32'd1234));
        begin
            int irq_left = 0;
            for (int i = 0; i < 3000; i++) begin
                bit fv, ff, idf, exf, mf;
                logic [4:0] fc, mc;
                fv  = ($urandom % 4) != 0;
                ff  = ($urandom % 16) == 0;
                idf = ($urandom % 16) == 0;
                exf = ($urandom % 16) == 0;
                mf  = ($urandom % 16) == 0;
                fc  = ($urandom % 2) ? 5'd4 : 5'd6;
                mc  = ($urandom % 2) ? 5'd5 : 5'd7;
                if (irq_left == 0 && ($urandom % 40) == 0) irq_left = 1 + ($urandom % 4);
                step(fv, ff, fc, idf, exf, mf, mc, irq_left != 0);
                if (irq_left != 0) irq_left--;
            end
        end
        bubbles(5);
        done = 1;
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule